// File: doc/BRIEF.md
# Precharge-Sequenced Asynchronous SRAM Controller

This block sits between a clocked host and an asynchronous 128K x 8 static RAM. It takes one single-word read or write request at a time through a valid/ready port and turns it into pin-level control timing. The RAM has an active-low select, an active-high enable, an active-low write strobe and an active-low output enable. The RAM data bus is exposed as separate out, in and output-enable vectors, so that a pad ring or an outer wrapper can join them into one tri-state bus.

Every access has three phases. The controller first latches the request. It then holds the select high for a precharge interval, so the RAM takes the new address. It then holds the select low for an access window long enough for a full RAM cycle. Both intervals are whole clock counts. They are derived from a clock-period parameter and rounded up, so the nanosecond minimums always hold. On a read, the RAM's data is captured on the last clock of the window and returned with a one-cycle valid pulse. The controller drives the data bus only inside a write window. The precharge interval therefore always separates a read's bus use from the next write's.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it, ramCsN=1, ramCe=0, ramWeN=1, ramOeN=1, ramDqOe=0, rspValid=0 and reqReady=1.
- R2: A request is accepted on a rising edge where reqValid and reqReady are both 1. reqReady then stays 0 until the access has finished, which is PRE_CYC+ACC_CYC cycles later.
- R3: Before every cycle in which ramCsN falls, ramCsN is held high for at least PRE_CYC = max(1, ceil(PRECHARGE_PS/CLK_PERIOD_PS)) cycles. This is 1 cycle with the default values.
- R4: Each low period of ramCsN lasts exactly ACC_CYC = max(1, ceil(ACCESS_PS/CLK_PERIOD_PS)) cycles. This is 2 cycles with the default values (20 ns clock, 32 ns access).
- R5: ramAddr and ramDqOut change only while ramCsN is high. Both stay stable through every low period of ramCsN.
- R6: During a read window: ramCsN=0, ramCe=1, ramWeN=1, ramOeN=0 and ramDqOe=0.
- R7: During a write window: ramCsN=0, ramCe=1, ramWeN=0, ramOeN=1, ramDqOe=1, and ramDqOut equals the request's write data. ramDqOe is 0 on every other cycle.
- R8: ramCe is 1 whenever ramCsN is 0, and ramCe is 0 while the controller is idle.
- R9: Read data is sampled from ramDqIn on the last clock of the read window. rspData is presented with rspValid=1 for exactly one cycle. That cycle comes PRE_CYC+ACC_CYC+1 cycles after the accepting edge.
- R10: When a read is followed directly by a write, there is at least one full cycle between the last cycle with the RAM output enabled and the first cycle with ramDqOe=1. In that cycle neither side drives the bus.
- R11: A write never raises rspValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 8 | Write data |
| rspValid | output | 1 | One-cycle read data valid |
| rspData | output | 8 | Read data |
| ramAddr | output | 17 | RAM address |
| ramCsN | output | 1 | RAM select, active low |
| ramCe | output | 1 | RAM enable, active high |
| ramWeN | output | 1 | RAM write strobe, active low |
| ramOeN | output | 1 | RAM output enable, active low |
| ramDqOut | output | 8 | Data driven toward the RAM |
| ramDqOe | output | 1 | Controller drives the data bus |
| ramDqIn | input | 8 | Data returned by the RAM |

## Verification
A wrong state or a wrong count shows up on the select line within one access. The select either falls with no high cycle before it, or stays low for too few or too many cycles. Either way the bench's pin monitor flags it on the cycle where the select changes. A lost write flag or a misplaced capture strobe shows up at the ports in a different way. The bench reads back a value other than the one it wrote, or the response pulse arrives on a cycle other than PRE_CYC+ACC_CYC+1 after acceptance. Bus contention shows up as the data-drive enable rising in a cycle that directly follows one in which the RAM's output was enabled.

// File: rtl/sramc_pkg.sv
package sramc_pkg;
  typedef struct packed {
    logic load;     // latch a new request into the datapath
    logic drive;    // drive write data onto the RAM bus
    logic capture;  // sample RAM read data
  } sramcStrobe_t;
endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int PRE_CYC = 1,
  parameter int ACC_CYC = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output logic         ramCsN,
  output logic         ramCe,
  output logic         ramWeN,
  output logic         ramOeN,
  output sramcStrobe_t strobe
);
  localparam int MAX_CYC = (PRE_CYC > ACC_CYC) ? PRE_CYC : ACC_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_ACT} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state   <= ST_PRE;
          cnt     <= CNT_W'(PRE_CYC - 1);
          isWrite <= reqWrite;
        end
        ST_PRE: if (cnt == '0) begin
          state <= ST_ACT;
          cnt   <= CNT_W'(ACC_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_ACT: if (cnt == '0) state <= ST_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady       = (state == ST_IDLE);
    ramCsN         = (state != ST_ACT);
    ramCe          = (state != ST_IDLE);
    ramWeN         = !((state == ST_ACT) && isWrite);
    ramOeN         = !((state == ST_ACT) && !isWrite);
    strobe.load    = (state == ST_IDLE) && reqValid;
    strobe.drive   = (state == ST_ACT) && isWrite;
    strobe.capture = (state == ST_ACT) && !isWrite && (cnt == '0);
  end

  // Pin-level interval counters used only by the checks below
  logic [CNT_W:0] hiCnt, loCnt;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiCnt <= '0;
      loCnt <= '0;
    end else if (ramCsN) begin
      loCnt <= '0;
      if (int'(hiCnt) < PRE_CYC) hiCnt <= hiCnt + 1'b1;
    end else begin
      hiCnt <= '0;
      if (int'(loCnt) <= ACC_CYC) loCnt <= loCnt + 1'b1;
    end
  end

  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ramCsN) |-> int'(hiCnt) >= PRE_CYC);  // R3
  AST_ACTIVE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramCsN) |-> int'(loCnt) == ACC_CYC);  // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    !ramCsN |-> !reqReady);  // R2
endmodule

// File: rtl/sramc_dpath.sv
module sramc_dpath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramcStrobe_t      strobe,
  input  logic              ramCsN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramDqIn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobe.load) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      rspValid <= strobe.capture;
      if (strobe.capture) rspData <= ramDqIn;
    end
  end

  assign ramAddr  = addrReg;
  assign ramDqOut = wdataReg;
  assign ramDqOe  = strobe.drive;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ramCsN && $past(!ramCsN)) |-> ($stable(ramAddr) && $stable(ramDqOut)));  // R5
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);  // R9
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 20000,
  parameter int PRECHARGE_PS  = 5000,
  parameter int ACCESS_PS     = 32000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramCsN,
  output logic              ramCe,
  output logic              ramWeN,
  output logic              ramOeN,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqOe,
  input  logic [DATA_W-1:0] ramDqIn
);
  localparam int PRE_RAW = (PRECHARGE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int ACC_RAW = (ACCESS_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int PRE_CYC = (PRE_RAW < 1) ? 1 : PRE_RAW;
  localparam int ACC_CYC = (ACC_RAW < 1) ? 1 : ACC_RAW;

  sramcStrobe_t strobe;

  sramc_ctrl #(.PRE_CYC(PRE_CYC), .ACC_CYC(ACC_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .ramCsN(ramCsN), .ramCe(ramCe), .ramWeN(ramWeN),
    .ramOeN(ramOeN), .strobe(strobe)
  );

  sramc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ramCsN(ramCsN),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ramDqIn(ramDqIn),
    .ramAddr(ramAddr), .ramDqOut(ramDqOut), .ramDqOe(ramDqOe),
    .rspValid(rspValid), .rspData(rspData)
  );

  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ramDqOe |-> (!ramWeN && !ramCsN && ramOeN));  // R7
  AST_CE_WITH_CS: assert property (@(posedge clk) disable iff (!rstN)
    !ramCsN |-> ramCe);  // R8
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !ramOeN |-> (!ramDqOe && ramWeN));  // R6
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    $past(!ramOeN) |-> !ramDqOe);  // R10
endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
  localparam int CLK_PS  = 20000;
  localparam int PRE_CYC = (5000 + CLK_PS - 1) / CLK_PS;   // 1
  localparam int ACC_CYC = (32000 + CLK_PS - 1) / CLK_PS;  // 2
  localparam int LAT     = PRE_CYC + ACC_CYC + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic reqReady, rspValid, ramCsN, ramCe, ramWeN, ramOeN, ramDqOe;
  logic [7:0] rspData, ramDqOut;
  logic [7:0] ramDqIn = 8'hEE;
  logic [16:0] ramAddr;

  int checks = 0, fails = 0;

  always #10ns clk = ~clk;

  sram_async_ctrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .ramAddr(ramAddr),
    .ramCsN(ramCsN), .ramCe(ramCe), .ramWeN(ramWeN), .ramOeN(ramOeN),
    .ramDqOut(ramDqOut), .ramDqOe(ramDqOe), .ramDqIn(ramDqIn)
  );

  // RAM model and pin monitor, sampled at falling edges
  logic [7:0] mem [logic [16:0]];
  int hiLen = 0, loLen = 0;
  int errPre = 0, errLen = 0, errStable = 0, errRead = 0, errWrite = 0;
  int errCe = 0, errTurn = 0, errRspW = 0;
  logic prevLow = 1'b0, prevOeLow = 1'b0, lastWasWrite = 1'b0;
  logic [16:0] prevAddr = '0;
  logic [7:0]  prevOut = '0;

  function automatic logic [7:0] peek(logic [16:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (!ramCsN) begin
        if (!prevLow && hiLen < PRE_CYC) errPre++;                // R3
        if (prevLow && (ramAddr != prevAddr || ramDqOut != prevOut)) errStable++; // R5
        if (!ramCe) errCe++;                                      // R8
        loLen++;
        hiLen = 0;
        if (!ramWeN) begin
          lastWasWrite = 1'b1;
          if (!ramOeN || !ramDqOe) errWrite++;                    // R7
          mem[ramAddr] = ramDqOut;
        end else begin
          lastWasWrite = 1'b0;
          if (ramOeN || ramDqOe) errRead++;                       // R6
        end
      end else begin
        if (prevLow && loLen != ACC_CYC) errLen++;                // R4
        loLen = 0;
        hiLen++;
        if (ramDqOe) errWrite++;                                  // R7
        if (!ramCe && 1'b0) errCe++;
      end
      if (ramDqOe && prevOeLow) errTurn++;                        // R10
      if (rspValid && lastWasWrite) errRspW++;                    // R11
      prevLow   = !ramCsN;
      prevOeLow = !ramOeN;
      prevAddr  = ramAddr;
      prevOut   = ramDqOut;
    end
    ramDqIn <= (!ramCsN && ramCe && ramWeN && !ramOeN) ? peek(ramAddr) : 8'hEE;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [16:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int lat);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr = ~a; reqWdata = ~d;  // must not reach the RAM pins (R5)
    lat = 1;
    check("R2 busy", {31'b0, reqReady}, 32'd0);
    while (!(wr ? reqReady : rspValid) && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd = rspData;
  endtask

  task automatic testReset();
    check("R1 csN", {31'b0, ramCsN}, 1);
    check("R1 ce", {31'b0, ramCe}, 0);
    check("R1 weN/oeN", {30'b0, ramWeN, ramOeN}, 3);
    check("R1 dqOe/rsp", {30'b0, ramDqOe, rspValid}, 0);
    check("R1 ready", {31'b0, reqReady}, 1);
  endtask

  task automatic testWriteRead(logic [16:0] a, logic [7:0] d);
    logic [7:0] rd; int lat;
    access(1'b1, a, d, rd, lat);
    check("R2 write done", lat, LAT);
    access(1'b0, a, 8'h00, rd, lat);
    check("R9 read latency", lat, LAT);
    check("R7 R9 read back", rd, d);
    @(negedge clk);
    check("R9 single pulse", {31'b0, rspValid}, 0);
  endtask

  task automatic testUnwritten(logic [16:0] a);
    logic [7:0] rd; int lat;
    access(1'b0, a, 8'h00, rd, lat);
    check("R9 unwritten", rd, {24'b0, a[7:0] ^ 8'h5A});
  endtask

  task automatic testReadThenWrite();
    logic [7:0] rd; int lat;
    access(1'b0, 17'h00100, 8'h00, rd, lat);
    access(1'b1, 17'h00101, 8'hC3, rd, lat);
    access(1'b0, 17'h00101, 8'h00, rd, lat);
    check("R10 after turnaround", rd, 8'hC3);
  endtask

  task automatic testMonitors();
    check("R3 precharge", errPre, 0);
    check("R4 active length", errLen, 0);
    check("R5 stable", errStable, 0);
    check("R6 read pins", errRead, 0);
    check("R7 write pins", errWrite, 0);
    check("R8 enable", errCe, 0);
    check("R10 turnaround", errTurn, 0);
    check("R11 no write rsp", errRspW, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteRead(17'h00000, 8'hA5);
    testWriteRead(17'h1FFFF, 8'h3C);
    testWriteRead(17'h0AAAA, 8'hFF);
    testUnwritten(17'h12345);
    testReadThenWrite();
    testWriteRead(17'h1FFFF, 8'h00);
    testMonitors();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule